// File: doc/BRIEF.md
# Interrupt acceptance sequencer

This block takes interrupt requests on behalf of a small 8-bit processor core and turns an accepted request into a change of the program counter. Each request sets a latch. A maskable latch competes for service only while the interrupt master enable flag (IMF) is 1 and the per-source enable bit for that source is 1. A single non-maskable source skips both gates. At an instruction boundary the sequencer picks the winning source and stalls the core. It then writes the return address and the status word to a byte-wide stack through a memory port. After that it reads a two-byte entry address from that source's slot in a fixed vector table and hands that address to the core as the new program counter.

IMF is bit 7 of the saved status word. Entry clears IMF. A return strobe pops the status word and the return address, which puts IMF back to the value it had before entry. Software can re-open nesting inside a service routine with the enable strobe. The disable strobe closes it again. General-purpose registers are not saved here.

The memory port is a valid/ready channel. The block raises `mem_valid` with the address, direction and write data. It holds all of them unchanged until the cycle in which `mem_ready` is 1, and that cycle completes the transfer. On a read, `mem_rdata` is taken in that same cycle. When the memory holds `mem_ready` low, the sequence stalls and `busy` stays high. With `mem_ready` held at 1, entry takes six cycles from the boundary cycle to the program-counter load. That is well inside a 38-clock latency budget even after the longest instruction in progress has finished.

Top module: `irq_accept_seq`

## Requirements
- R1: After reset, `busy`, `mem_valid`, `pc_load`, `psw_load` and `imf` are 0, and `sp` equals the reset stack value 16'h007F.
- R2: A maskable latch is served only while `imf` is 1 and its `irq_en` bit is 1. A latch whose source is disabled stays pending and is served once its enable bit is set.
- R3: The non-maskable latch outranks every maskable one. Among pending, enabled maskable latches, the lowest index wins.
- R4: Acceptance happens only in a cycle where the sequencer is idle and `boundary` is 1. `busy` is 1 in that cycle, combinationally, and stays 1 through the cycle that pulses `pc_load`.
- R5: Entry writes three bytes with the stack pointer decrementing after each write. The return PC high byte goes to SP, the low byte to SP-1, and the status word {imf, flags_cur} to SP-2. `sp` ends at SP-3.
- R6: Entry reads the low byte of the entry address at vector address V and the high byte at V+1, then loads `pc_out` = {high, low}. V is 16'hFFFC for the non-maskable source and 16'hFFFA - 2*i for maskable source i.
- R7: Acceptance clears `imf` and clears the latch of the served source. The saved status word carries the IMF value from before entry in bit 7.
- R8: The non-maskable source is served while `imf` is 0 and `irq_en` is 0. It can be served again inside its own service routine, with each entry stacking three more bytes.
- R9: `reti` at a boundary pops the status word from SP+1, the PC low byte from SP+2 and the high byte from SP+3. It then pulses `pc_load` and `psw_load` together, with the popped PC on `pc_out`, the popped flags on `flags_out` and the popped bit 7 in `imf`. `sp` returns to its value from before entry.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, the address, direction and write data hold steady and the sequence waits. With `mem_ready` at 1, `pc_load` comes 6 cycles after the acceptance cycle on entry, and 4 cycles after the strobe cycle on return.
- R11: In idle, `ei` sets `imf` and `di` clears it. When both are given in the same cycle, `di` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req | input | NSRC | Maskable request pulses, one per source |
| nmi_req | input | 1 | Non-maskable request pulse |
| irq_en | input | NSRC | Per-source enable bits |
| boundary | input | 1 | Core is at an instruction boundary |
| reti | input | 1 | Return-from-interrupt strobe, valid with boundary |
| ei | input | 1 | Set IMF |
| di | input | 1 | Clear IMF |
| pc_cur | input | 2*DW | Return address of the interrupted program |
| flags_cur | input | DW-1 | Core status flags (status word without IMF) |
| busy | output | 1 | Stall request to the core |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 2*DW | Entry address or popped return address |
| psw_load | output | 1 | Load `flags_out` into the core flags |
| flags_out | output | DW-1 | Popped status flags |
| imf | output | 1 | Interrupt master enable flag |
| sp | output | 2*DW | Stack pointer |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts or returns in this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 2*DW | Memory byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, taken when valid and ready |

## Verification
The bench sends requests that race each other and checks which source wins. A broken priority chain, or one that ignores IMF or the enable bits, would load the wrong entry address. It also checks that a disabled latch is still pending later: a design that dropped it would never enter.

It checks the stacked byte order and the final stack pointer, and it returns with IMF cleared by software. A wrong push order, or a failure to restore IMF from the popped word, would show up as a wrong byte in memory or a wrong `imf` after return.

It nests the non-maskable source twice with IMF at 0, stalls the memory port every other cycle, and holds a request pending with no boundary. These catch a design that gates the non-maskable source, skips a transfer while `mem_ready` is low, or enters in the middle of an instruction.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH_PCH,
    S_PUSH_PCL,
    S_PUSH_PSW,
    S_VEC_LO,
    S_VEC_HI,
    S_ENTER,
    S_POP_PSW,
    S_POP_PCL,
    S_POP_PCH,
    S_LEAVE
  } seq_state_e;

  function automatic logic state_is_push(input seq_state_e s);
    return (s == S_PUSH_PCH) || (s == S_PUSH_PCL) || (s == S_PUSH_PSW);
  endfunction

  function automatic logic state_is_pop(input seq_state_e s);
    return (s == S_POP_PSW) || (s == S_POP_PCL) || (s == S_POP_PCH);
  endfunction

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NSRC = 4,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] cand,
  output logic [NSRC-1:0] grant,
  output logic [IW-1:0]   grant_idx,
  output logic            any
);

  for (genvar i = 0; i < NSRC; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign grant[i] = cand[i];
    end else begin : g_rest
      assign grant[i] = cand[i] & ~(|cand[i-1:0]);
    end
  end

  always_comb begin
    grant_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) grant_idx = IW'(i);
    end
  end

  assign any = |cand;

endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int NSRC = 4,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req,
  input  logic            nmi_req,
  input  logic [NSRC-1:0] ien,
  input  logic            imf,
  input  logic            take,
  output logic            pend,
  output logic            pick_nmi,
  output logic [NSRC-1:0] grant,
  output logic [IW-1:0]   grant_idx
);

  logic [NSRC-1:0] lat_q;
  logic            nmi_q;
  logic [NSRC-1:0] cand;
  logic [NSRC-1:0] grant_raw;
  logic            any_mask;
  logic [NSRC-1:0] clr_mask;

  assign cand = imf ? (lat_q & ien) : '0;

  irq_prio_pick #(.NSRC(NSRC)) i_pick (
    .cand      (cand),
    .grant     (grant_raw),
    .grant_idx (grant_idx),
    .any       (any_mask)
  );

  assign pick_nmi = nmi_q;
  assign grant    = nmi_q ? '0 : grant_raw;
  assign pend     = nmi_q | any_mask;
  assign clr_mask = take ? grant : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      nmi_q <= 1'b0;
    end else begin
      lat_q <= (lat_q & ~clr_mask) | req;
      nmi_q <= (nmi_q & ~take) | nmi_req;
    end
  end

  a_r3_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nmi_q, grant}));

  a_r2_grant_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant) |-> (imf && ((grant & ien & lat_q) == grant)));

  a_r7_latch_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ((req & grant) == '0)) |=> ((lat_q & $past(grant)) == '0));

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int               DW      = 8,
  parameter int               NSRC    = 4,
  parameter logic [2*DW-1:0]  SP_INIT = 16'h007F,
  parameter logic [2*DW-1:0]  VEC_NMI = 16'hFFFC,
  localparam int AW = 2 * DW,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_irq,
  input  logic          start_ret,
  input  logic          take_nmi,
  input  logic [IW-1:0] take_idx,
  input  logic [AW-1:0] ret_pc,
  input  logic [DW-1:0] psw_snap,
  output logic          active,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] sp,
  output logic          pc_load,
  output logic [AW-1:0] pc_out,
  output logic          psw_load,
  output logic [DW-1:0] psw_out,
  output logic          imf_restore,
  output logic          imf_value
);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] sp_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] psw_q;
  logic [AW-1:0] vec_q;
  logic          xfer;

  assign xfer = mem_valid && mem_ready;

  always_comb begin
    mem_valid = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = sp_q;
    mem_wdata = '0;
    unique case (state_q)
      S_PUSH_PCH: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pc_q[AW-1:DW];
      end
      S_PUSH_PCL: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = pc_q[DW-1:0];
      end
      S_PUSH_PSW: begin
        mem_valid = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = psw_q;
      end
      S_VEC_LO: begin
        mem_valid = 1'b1;
        mem_addr  = vec_q;
      end
      S_VEC_HI: begin
        mem_valid = 1'b1;
        mem_addr  = vec_q + AW'(1);
      end
      S_POP_PSW, S_POP_PCL, S_POP_PCH: begin
        mem_valid = 1'b1;
        mem_addr  = sp_q + AW'(1);
      end
      default: ;
    endcase
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (start_ret)      state_d = S_POP_PSW;
        else if (start_irq) state_d = S_PUSH_PCH;
      end
      S_PUSH_PCH: if (xfer) state_d = S_PUSH_PCL;
      S_PUSH_PCL: if (xfer) state_d = S_PUSH_PSW;
      S_PUSH_PSW: if (xfer) state_d = S_VEC_LO;
      S_VEC_LO:   if (xfer) state_d = S_VEC_HI;
      S_VEC_HI:   if (xfer) state_d = S_ENTER;
      S_POP_PSW:  if (xfer) state_d = S_POP_PCL;
      S_POP_PCL:  if (xfer) state_d = S_POP_PCH;
      S_POP_PCH:  if (xfer) state_d = S_LEAVE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      sp_q    <= SP_INIT;
      pc_q    <= '0;
      psw_q   <= '0;
      vec_q   <= VEC_NMI;
    end else begin
      state_q <= state_d;
      if (state_q == S_IDLE && start_irq && !start_ret) begin
        pc_q  <= ret_pc;
        psw_q <= psw_snap;
        vec_q <= take_nmi ? VEC_NMI
                          : VEC_NMI - ((AW'(take_idx) + AW'(1)) << 1);
      end
      if (xfer) begin
        if (state_is_push(state_q)) sp_q <= sp_q - AW'(1);
        if (state_is_pop(state_q))  sp_q <= sp_q + AW'(1);
        unique case (state_q)
          S_VEC_LO, S_POP_PCL: pc_q[DW-1:0]  <= mem_rdata;
          S_VEC_HI, S_POP_PCH: pc_q[AW-1:DW] <= mem_rdata;
          S_POP_PSW:           psw_q         <= mem_rdata;
          default: ;
        endcase
      end
    end
  end

  assign active      = (state_q != S_IDLE);
  assign sp          = sp_q;
  assign pc_out      = pc_q;
  assign psw_out     = psw_q;
  assign pc_load     = (state_q == S_ENTER) || (state_q == S_LEAVE);
  assign psw_load    = (state_q == S_LEAVE);
  assign imf_restore = (state_q == S_POP_PSW) && xfer;
  assign imf_value   = mem_rdata[DW-1];

  a_r10_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  a_r10_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);

  a_r5_sp_down_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && mem_we) |=> (sp == $past(sp) - AW'(1)));

  a_r9_sp_up_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready && !mem_we && mem_addr == sp + AW'(1)) |=>
      (sp == $past(sp) + AW'(1)));

endmodule

// File: rtl/irq_accept_seq.sv
module irq_accept_seq #(
  parameter int               DW      = 8,
  parameter int               NSRC    = 4,
  parameter logic [2*DW-1:0]  SP_INIT = 16'h007F,
  parameter logic [2*DW-1:0]  VEC_NMI = 16'hFFFC,
  localparam int AW = 2 * DW,
  localparam int FW = DW - 1,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic            nmi_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic            boundary,
  input  logic            reti,
  input  logic            ei,
  input  logic            di,
  input  logic [AW-1:0]   pc_cur,
  input  logic [FW-1:0]   flags_cur,
  output logic            busy,
  output logic            pc_load,
  output logic [AW-1:0]   pc_out,
  output logic            psw_load,
  output logic [FW-1:0]   flags_out,
  output logic            imf,
  output logic [AW-1:0]   sp,
  output logic            mem_valid,
  input  logic            mem_ready,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata
);

  logic            imf_q;
  logic            seq_active;
  logic            pend;
  logic            pick_nmi;
  logic [NSRC-1:0] grant;
  logic [IW-1:0]   grant_idx;
  logic            accept;
  logic            ret_go;
  logic            imf_restore;
  logic            imf_value;
  logic [DW-1:0]   psw_full;

  assign ret_go = !seq_active && boundary && reti;
  assign accept = !seq_active && boundary && !reti && pend;

  irq_latch_bank #(.NSRC(NSRC)) i_latch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (irq_req),
    .nmi_req   (nmi_req),
    .ien       (irq_en),
    .imf       (imf_q),
    .take      (accept),
    .pend      (pend),
    .pick_nmi  (pick_nmi),
    .grant     (grant),
    .grant_idx (grant_idx)
  );

  irq_stack_seq #(
    .DW      (DW),
    .NSRC    (NSRC),
    .SP_INIT (SP_INIT),
    .VEC_NMI (VEC_NMI)
  ) i_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_irq   (accept),
    .start_ret   (ret_go),
    .take_nmi    (pick_nmi),
    .take_idx    (grant_idx),
    .ret_pc      (pc_cur),
    .psw_snap    ({imf_q, flags_cur}),
    .active      (seq_active),
    .mem_valid   (mem_valid),
    .mem_ready   (mem_ready),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .sp          (sp),
    .pc_load     (pc_load),
    .pc_out      (pc_out),
    .psw_load    (psw_load),
    .psw_out     (psw_full),
    .imf_restore (imf_restore),
    .imf_value   (imf_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      imf_q <= 1'b0;
    end else if (accept) begin
      imf_q <= 1'b0;
    end else if (imf_restore) begin
      imf_q <= imf_value;
    end else if (!seq_active && di) begin
      imf_q <= 1'b0;
    end else if (!seq_active && ei) begin
      imf_q <= 1'b1;
    end
  end

  assign imf       = imf_q;
  assign busy      = seq_active | accept | ret_go;
  assign flags_out = psw_full[FW-1:0];

  a_r7_imf_off_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !imf);

  a_r4_start_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> boundary);

  a_r4_busy_with_load: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> busy);

  a_r2_maskable_needs_imf: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !pick_nmi) |-> imf);

endmodule

// File: tb/test_irq_accept_seq.sv
module test_irq_accept_seq;

  localparam int NSRC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  irq_req = '0;
  logic        nmi_req = 1'b0;
  logic [3:0]  irq_en = '0;
  logic        boundary = 1'b0;
  logic        reti = 1'b0;
  logic        ei = 1'b0;
  logic        di = 1'b0;
  logic [15:0] pc_cur = '0;
  logic [6:0]  flags_cur = '0;
  logic        busy, pc_load, psw_load, imf;
  logic [15:0] pc_out, sp, mem_addr;
  logic [6:0]  flags_out;
  logic        mem_valid, mem_ready, mem_we;
  logic [7:0]  mem_wdata, mem_rdata;

  logic        stall = 1'b0;
  logic        tog = 1'b0;
  logic [7:0]  ram [256];
  int          errors = 0;
  int          checks = 0;

  always #2 clk = ~clk;

  irq_accept_seq i_irq_accept_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
    .irq_en(irq_en), .boundary(boundary), .reti(reti), .ei(ei), .di(di),
    .pc_cur(pc_cur), .flags_cur(flags_cur), .busy(busy), .pc_load(pc_load),
    .pc_out(pc_out), .psw_load(psw_load), .flags_out(flags_out), .imf(imf),
    .sp(sp), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [15:0] exp_entry(input int code);
    if (code == 4) return 16'hE1C5;
    return {8'hD0 + 8'(code), 8'h03 + 8'(code) * 8'h10};
  endfunction

  function automatic logic [7:0] vec_byte(input logic [15:0] a);
    logic [15:0] e;
    if (a == 16'hFFFC || a == 16'hFFFD) e = exp_entry(4);
    else e = exp_entry(int'((16'hFFFB - a) >> 1));
    return a[0] ? e[15:8] : e[7:0];
  endfunction

  assign mem_ready = stall ? tog : 1'b1;
  assign mem_rdata = (mem_addr[15:8] == 8'hFF) ? vec_byte(mem_addr) : ram[mem_addr[7:0]];

  always @(negedge clk) tog <= ~tog;
  always @(posedge clk) if (mem_valid && mem_ready && mem_we) ram[mem_addr[7:0]] <= mem_wdata;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; irq_req = '0; nmi_req = 1'b0; irq_en = '0; boundary = 1'b0;
    reti = 1'b0; ei = 1'b0; di = 1'b0; stall = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_ei(); ei = 1'b1; @(negedge clk); ei = 1'b0; endtask
  task automatic pulse_di(); di = 1'b1; @(negedge clk); di = 1'b0; endtask

  task automatic pulse_req(input logic [3:0] r, input logic n);
    irq_req = r; nmi_req = n; @(negedge clk); irq_req = '0; nmi_req = 1'b0;
  endtask

  task automatic accept(output int n);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
    n = 1;
    while (!pc_load && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic no_accept(input string tag);
    boundary = 1'b1;
    #1 chk(tag, busy, 1'b0);
    @(negedge clk);
    boundary = 1'b0;
    repeat (8) begin
      @(negedge clk);
      chk(tag, {busy, pc_load}, 2'b00);
    end
  endtask

  // {ien[3:0], ei, req[3:0], nmi, expected code (0..3 source, 4 nmi, 7 none)}
  localparam logic [12:0] TV [10] = '{
    {4'hF,    1'b1, 4'b0001, 1'b0, 3'd0},
    {4'hF,    1'b1, 4'b0110, 1'b0, 3'd1},
    {4'hF,    1'b1, 4'b1100, 1'b0, 3'd2},
    {4'hF,    1'b1, 4'b1000, 1'b0, 3'd3},
    {4'hF,    1'b0, 4'b0001, 1'b0, 3'd7},
    {4'b1110, 1'b1, 4'b0001, 1'b0, 3'd7},
    {4'b1110, 1'b1, 4'b0011, 1'b0, 3'd1},
    {4'h0,    1'b0, 4'b1111, 1'b1, 3'd4},
    {4'hF,    1'b1, 4'b0001, 1'b1, 3'd4},
    {4'b0100, 1'b1, 4'b1111, 1'b0, 3'd2}
  };

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    do_reset();

    // R1 reset state
    chk("R1 busy", busy, 1'b0);
    chk("R1 mem_valid", mem_valid, 1'b0);
    chk("R1 pc_load", {pc_load, psw_load}, 2'b00);
    chk("R1 imf", imf, 1'b0);
    chk("R1 sp", sp, 16'h007F);

    // R2 R3 R6 R8: table of gating and priority cases
    for (int t = 0; t < 10; t++) begin
      do_reset();
      irq_en = TV[t][12:9];
      if (TV[t][8]) pulse_ei();
      pulse_req(TV[t][7:4], TV[t][3]);
      if (TV[t][2:0] == 3'd7) begin
        no_accept("R2 gated source");
      end else begin
        accept(n);
        chk("R3 R6 entry address", pc_out, exp_entry(int'(TV[t][2:0])));
      end
    end

    // R5 R6 R7 R10: entry stacking and timing
    do_reset();
    irq_en = 4'hF;
    pulse_ei();
    pc_cur = 16'h1234; flags_cur = 7'h55;
    pulse_req(4'b0010, 1'b0);
    accept(n);
    chk("R10 entry latency", n, 6);
    chk("R6 entry src1", pc_out, exp_entry(1));
    chk("R5 pch at sp", ram[8'h7F], 8'h12);
    chk("R5 pcl at sp-1", ram[8'h7E], 8'h34);
    chk("R5 R7 psw at sp-2", ram[8'h7D], 8'hD5);
    chk("R5 sp after entry", sp, 16'h007C);
    chk("R7 imf cleared", imf, 1'b0);
    pulse_ei();
    no_accept("R7 latch cleared");

    // R9 R10: return restores IMF, flags, PC and SP
    pulse_di();
    chk("R11 di", imf, 1'b0);
    flags_cur = 7'h00; pc_cur = 16'h0000;
    reti = 1'b1;
    accept(n);
    reti = 1'b0;
    chk("R10 return latency", n, 4);
    chk("R9 return pc", pc_out, 16'h1234);
    chk("R9 flags", flags_out, 7'h55);
    chk("R9 psw_load", psw_load, 1'b1);
    chk("R9 imf restored", imf, 1'b1);
    chk("R9 sp restored", sp, 16'h007F);

    // R8 nested non-maskable entries with imf 0
    do_reset();
    pulse_req(4'b0000, 1'b1);
    accept(n);
    chk("R8 nmi entry", pc_out, exp_entry(4));
    chk("R8 sp first", sp, 16'h007C);
    pulse_req(4'b0000, 1'b1);
    accept(n);
    chk("R8 nmi nested", pc_out, exp_entry(4));
    chk("R8 sp nested", sp, 16'h0079);
    chk("R8 nested psw", ram[8'h7A], 8'h00);

    // R2 pending latch survives while disabled
    do_reset();
    pulse_ei();
    pulse_req(4'b1000, 1'b0);
    no_accept("R2 disabled held");
    irq_en = 4'b1000;
    accept(n);
    chk("R2 served after enable", pc_out, exp_entry(3));

    // R4 no entry without a boundary
    do_reset();
    irq_en = 4'hF;
    pulse_ei();
    pulse_req(4'b0001, 1'b0);
    repeat (5) @(negedge clk);
    chk("R4 idle without boundary", busy, 1'b0);
    boundary = 1'b1;
    #1 chk("R4 busy in accept cycle", busy, 1'b1);
    accept(n);
    chk("R4 entry latency", n, 6);

    // R10 stalled memory port
    do_reset();
    irq_en = 4'hF;
    pulse_ei();
    pc_cur = 16'hA55A; flags_cur = 7'h0F;
    pulse_req(4'b0100, 1'b0);
    stall = 1'b1;
    accept(n);
    stall = 1'b0;
    chk("R10 stall lengthens", (n > 6 && n < 40), 1'b1);
    chk("R10 stall entry", pc_out, exp_entry(2));
    chk("R10 stall pch", ram[8'h7F], 8'hA5);
    chk("R10 stall pcl", ram[8'h7E], 8'h5A);
    chk("R10 stall psw", ram[8'h7D], 8'h8F);

    // R11 enable and disable strobes
    do_reset();
    pulse_ei();
    chk("R11 ei", imf, 1'b1);
    pulse_di();
    chk("R11 di", imf, 1'b0);
    pulse_ei();
    ei = 1'b1; di = 1'b1;
    @(negedge clk);
    ei = 1'b0; di = 1'b0;
    chk("R11 di wins", imf, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule